// File: doc/BRIEF.md
# SDRAM Single-Word Access Controller

This block sits between a simple host port and one 16-bit, four-bank synchronous DRAM. It brings the memory up after power is applied, and from then on it turns each host request into a row-open, column-access, row-close command sequence on the memory pins. It also inserts periodic refresh. Requests are served one at a time, with one data word per request. The controller programs the memory for a burst of one. Every row is closed again before the next request is taken, either by the column command itself or by an explicit close command.

All memory-side outputs are registered and change on the rising clock edge. The memory samples them on the following edge. The data bus is split into an output word, an output enable and an input word, and the pad ring joins them into the shared bus. Every timing window is a parameter counted in clock cycles. The read latency (2 or 3) is also a parameter. It fixes both the cycle in which read data is captured and the cycle in which the read byte mask must already be present.

Top module: `sdram_ctrl`

## Requirements
- R1: After reset release, chip select stays high (no command) for at least T_INIT clock edges, and ready_o stays low until the whole start-up sequence has been issued.
- R2: The start-up sequence is, in order: close-all-banks (precharge with A10 high), two auto-refresh commands, then a mode register load with bank bits 00, A[2:0]=000 (burst of one), A3=0, A[6:4]=CAS_LAT and all other address bits zero.
- R3: Commands are issued with cs_n low and {ras_n,cas_n,we_n} set to: 011 row open, 101 read, 100 write, 010 precharge, 001 auto-refresh, 000 mode load. In all idle and wait cycles cs_n is high.
- R4: The host word address is split as addr_i[23:22] bank, addr_i[21:9] row, addr_i[8:0] column. The row goes out on A0-A12 with the row-open command. The column goes out on A0-A8 with read or write, and A9, A11 and A12 are zero there.
- R5: Spacing between commands is at least T_RCD from row open to read or write, T_RP from precharge to the next command, T_RFC after refresh, T_MRD after mode load, and T_WR+1 from write to precharge.
- R6: With auto_pre_i high, A10 is high on the read or write and no precharge follows. With auto_pre_i low, A10 is low, and a precharge with A10 low to the same bank follows before any other row open or refresh.
- R7: On the write command cycle, dq_o carries the write word, dq_oe_o is high, and dqm_o equals the inverted byte enables (bit 0 is the low byte). dq_oe_o is low in every other cycle.
- R8: For a read, dqm_o equals the inverted byte enables on the cycle CAS_LAT-2 cycles after the read command, and is 11 in the other cycles of the read. The bus word is captured CAS_LAT cycles after the memory sees the read, and it is presented on rdata_o with a one-cycle rvalid_o pulse.
- R9: A refresh request is raised every REF_INTERVAL cycles. It is served with an auto-refresh command as soon as the current access has finished, ahead of any waiting host request, and with all banks closed.
- R10: A request is taken on a cycle where req_i and ready_o are both high. Each accepted read returns exactly one rvalid_o pulse, and results come back in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, shared with the memory |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Host request |
| we_i | input | 1 | 1 = write, 0 = read |
| auto_pre_i | input | 1 | Close the row with the column command |
| addr_i | input | 24 | Word address {bank, row, column} |
| wdata_i | input | 16 | Write word |
| be_i | input | 2 | Byte enables, bit 0 = low byte |
| ready_o | output | 1 | Controller can take a request |
| rvalid_o | output | 1 | Read word valid |
| rdata_o | output | 16 | Read word |
| cke_o | output | 1 | Clock enable to memory |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write strobe, active low |
| ba_o | output | 2 | Bank select |
| a_o | output | 13 | Multiplexed address |
| dqm_o | output | 2 | Byte masks, high = masked |
| dq_o | output | 16 | Write data to pads |
| dq_oe_o | output | 1 | Pad output enable |
| dq_i | input | 16 | Read data from pads |

## Verification
The bench's memory model honours the two mask latencies literally. When a read byte is masked, the model floats that byte to zero, so a read mask placed one cycle early or late corrupts the returned word. A write mask that is not aligned with its data overwrites bytes that a later full read exposes. The model keeps its own row state and timestamps. A close command with the wrong A10 or the wrong bank shows up as a row open to a bank that is already open. The model also flags short spacings and a start-up order that is wrong or incomplete. Long idle stretches check refresh spacing, and reads to column 511, row 8191 and bank 3 check the address split at its extremes.

// File: rtl/sdram_ctrl_pkg.sv
package sdram_ctrl_pkg;
  localparam int BANK_W = 2;
  localparam int ROW_W  = 13;
  localparam int COL_W  = 9;
  localparam int HADR_W = BANK_W + ROW_W + COL_W;
  localparam int DATA_W = 16;
  localparam int BE_W   = DATA_W / 8;

  // {ras_n, cas_n, we_n}; NOP doubles as deselect
  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [2:0] {
    S_WAIT, S_IPRE, S_IREF1, S_IREF2, S_IMRS, S_IDLE, S_RW, S_CLOSE
  } state_e;

  typedef struct packed {
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
  } haddr_t;

  function automatic int max2(int a, int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sdram_delay.sv
module sdram_delay #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= W'(RST_VAL);
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // a new window only opens once the previous one has run out
  AST_LOAD_WHEN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |-> done_o); // R5
endmodule

// File: rtl/sdram_ref_timer.sv
module sdram_ref_timer #(
  parameter int INTERVAL = 1040
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ack_i,
  output logic pend_o
);
  localparam int CW = $clog2(INTERVAL + 1);
  logic [CW-1:0] cnt_q;
  logic          wrap;

  assign wrap = (cnt_q == CW'(INTERVAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      pend_o <= 1'b0;
    end else begin
      cnt_q <= wrap ? '0 : cnt_q + 1'b1;
      if (wrap)       pend_o <= 1'b1;
      else if (ack_i) pend_o <= 1'b0;
    end
  end

  AST_REF_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_o && !ack_i |=> pend_o); // R9
  AST_REF_ACK_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |-> pend_o); // R9
endmodule

// File: rtl/sdram_rd_pipe.sv
module sdram_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int DW      = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          issue_i,
  input  logic [DW-1:0] dq_i,
  output logic          mask_now_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o
);
  logic [CAS_LAT:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q     <= '0;
      rvalid_o <= 1'b0;
      rdata_o  <= '0;
    end else begin
      sh_q     <= {sh_q[CAS_LAT-1:0], issue_i};
      rvalid_o <= sh_q[CAS_LAT];
      if (sh_q[CAS_LAT]) rdata_o <= dq_i;
    end
  end

  // read mask acts two cycles later than it is sampled
  generate
    if (CAS_LAT <= 2) begin : g_mask_cl2
      assign mask_now_o = issue_i;
    end else begin : g_mask_late
      assign mask_now_o = sh_q[CAS_LAT-3];
    end
  endgenerate

  AST_RVALID_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |=> !rvalid_o); // R10
  AST_NO_OVERLAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_i |-> (sh_q == '0)); // R8
endmodule

// File: rtl/sdram_ctrl.sv
module sdram_ctrl
  import sdram_ctrl_pkg::*;
#(
  parameter int CAS_LAT      = 2,
  parameter int T_INIT       = 2000,
  parameter int T_RP         = 3,
  parameter int T_RCD        = 3,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 2,
  parameter int REF_INTERVAL = 1040
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic              auto_pre_i,
  input  logic [HADR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [BE_W-1:0]   be_i,
  output logic              ready_o,
  output logic              rvalid_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              cke_o,
  output logic              cs_n_o,
  output logic              ras_n_o,
  output logic              cas_n_o,
  output logic              we_n_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [ROW_W-1:0]  a_o,
  output logic [BE_W-1:0]   dqm_o,
  output logic [DATA_W-1:0] dq_o,
  output logic              dq_oe_o,
  input  logic [DATA_W-1:0] dq_i
);
  localparam int MAXD = max2(max2(T_INIT, T_RFC), max2(max2(T_RP, T_RCD),
                        max2(max2(T_MRD, T_WR + 1), CAS_LAT + 1)));
  localparam int TW   = $clog2(MAXD + 1);

  state_e            state_q, state_d, ret_q, ret_d;
  cmd_e              cmd_d;
  logic [BANK_W-1:0] ba_d;
  logic [ROW_W-1:0]  a_d;
  haddr_t            rq_q, req_addr;
  logic              rq_we_q, rq_ap_q;
  logic [DATA_W-1:0] rq_wdata_q;
  logic [BE_W-1:0]   rq_be_q;
  logic              tmr_load, tmr_done;
  logic [TW-1:0]     tmr_val;
  logic              ref_pend, ref_ack;
  logic              accept, rd_issue, rd_mask_now;

  assign req_addr = haddr_t'(addr_i);
  assign ready_o  = (state_q == S_IDLE) && !ref_pend;
  assign accept   = ready_o && req_i;
  assign rd_issue = (state_q == S_RW) && !rq_we_q;

  sdram_delay #(.W(TW), .RST_VAL(T_INIT - 1)) u_delay (
    .clk_i, .rst_ni, .load_i(tmr_load), .val_i(tmr_val), .done_o(tmr_done)
  );

  sdram_ref_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk_i, .rst_ni, .ack_i(ref_ack), .pend_o(ref_pend)
  );

  sdram_rd_pipe #(.CAS_LAT(CAS_LAT), .DW(DATA_W)) u_rd (
    .clk_i, .rst_ni, .issue_i(rd_issue), .dq_i,
    .mask_now_o(rd_mask_now), .rvalid_o, .rdata_o
  );

  always_comb begin
    state_d  = state_q;
    ret_d    = ret_q;
    cmd_d    = CMD_NOP;
    ba_d     = '0;
    a_d      = '0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    ref_ack  = 1'b0;
    unique case (state_q)
      S_WAIT: if (tmr_done) state_d = ret_q;
      S_IPRE: begin
        cmd_d = CMD_PRE; a_d[10] = 1'b1;
        tmr_load = 1'b1; tmr_val = TW'(T_RP - 2); state_d = S_WAIT; ret_d = S_IREF1;
      end
      S_IREF1: begin
        cmd_d = CMD_REF;
        tmr_load = 1'b1; tmr_val = TW'(T_RFC - 2); state_d = S_WAIT; ret_d = S_IREF2;
      end
      S_IREF2: begin
        cmd_d = CMD_REF;
        tmr_load = 1'b1; tmr_val = TW'(T_RFC - 2); state_d = S_WAIT; ret_d = S_IMRS;
      end
      S_IMRS: begin
        cmd_d = CMD_MRS; a_d[6:4] = 3'(CAS_LAT);
        tmr_load = 1'b1; tmr_val = TW'(T_MRD - 2); state_d = S_WAIT; ret_d = S_IDLE;
      end
      S_IDLE: begin
        if (ref_pend) begin
          cmd_d = CMD_REF; ref_ack = 1'b1;
          tmr_load = 1'b1; tmr_val = TW'(T_RFC - 2); state_d = S_WAIT; ret_d = S_IDLE;
        end else if (req_i) begin
          cmd_d = CMD_ACT; ba_d = req_addr.bank; a_d = req_addr.row;
          tmr_load = 1'b1; tmr_val = TW'(T_RCD - 2); state_d = S_WAIT; ret_d = S_RW;
        end
      end
      S_RW: begin
        cmd_d = rq_we_q ? CMD_WR : CMD_RD;
        ba_d  = rq_q.bank;
        a_d[COL_W-1:0] = rq_q.col;
        a_d[10] = rq_ap_q;
        tmr_load = 1'b1;
        tmr_val  = rq_we_q ? TW'(T_WR - 1) : TW'(CAS_LAT - 1);
        state_d  = S_WAIT; ret_d = S_CLOSE;
      end
      S_CLOSE: begin
        if (!rq_ap_q) begin
          cmd_d = CMD_PRE; ba_d = rq_q.bank;
        end
        tmr_load = 1'b1; tmr_val = TW'(T_RP - 2); state_d = S_WAIT; ret_d = S_IDLE;
      end
      default: state_d = S_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_WAIT;
      ret_q      <= S_IPRE;
      cke_o      <= 1'b0;
      cs_n_o     <= 1'b1;
      {ras_n_o, cas_n_o, we_n_o} <= 3'b111;
      ba_o       <= '0;
      a_o        <= '0;
      dqm_o      <= '1;
      dq_o       <= '0;
      dq_oe_o    <= 1'b0;
      rq_q       <= '0;
      rq_we_q    <= 1'b0;
      rq_ap_q    <= 1'b0;
      rq_wdata_q <= '0;
      rq_be_q    <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      cke_o   <= 1'b1;
      cs_n_o  <= (cmd_d == CMD_NOP);
      {ras_n_o, cas_n_o, we_n_o} <= cmd_d;
      ba_o    <= ba_d;
      a_o     <= a_d;
      dq_oe_o <= (state_q == S_RW) && rq_we_q;
      dq_o    <= rq_wdata_q;
      if (((state_q == S_RW) && rq_we_q) || rd_mask_now) dqm_o <= ~rq_be_q;
      else                                               dqm_o <= '1;
      if (accept) begin
        rq_q       <= req_addr;
        rq_we_q    <= we_i;
        rq_ap_q    <= auto_pre_i;
        rq_wdata_q <= wdata_i;
        rq_be_q    <= be_i;
      end
    end
  end

  AST_ACT_THEN_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && {ras_n_o, cas_n_o, we_n_o} == CMD_ACT) |=> cs_n_o); // R5
  AST_OE_ONLY_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dq_oe_o |-> (!cs_n_o && {ras_n_o, cas_n_o, we_n_o} == CMD_WR)); // R7
  AST_WRITE_DRIVES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_n_o && {ras_n_o, cas_n_o, we_n_o} == CMD_WR) |-> dq_oe_o); // R7
  AST_READY_DESEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> cs_n_o); // R3
  AST_REF_BLOCKS_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ack |-> !ready_o); // R9
endmodule

// File: tb/sdram_ctrl_test.sv
`timescale 1ns/1ps
module sdram_ctrl_test;
  localparam int CL = 3, TINIT = 50, TRP = 3, TRCD = 3, TRFC = 7, TMRD = 2, TWR = 2;
  localparam int REFI = 300, SLACK = 30;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0, ap = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  be = '0;
  logic ready, rvalid, cke, cs_n, ras_n, cas_n, we_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [15:0] dq_i = '0;
  logic [1:0]  ba, dqm;
  logic [12:0] a;

  always #4 clk = ~clk;

  sdram_ctrl #(.CAS_LAT(CL), .T_INIT(TINIT), .T_RP(TRP), .T_RCD(TRCD), .T_RFC(TRFC),
               .T_MRD(TMRD), .T_WR(TWR), .REF_INTERVAL(REFI)) uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .auto_pre_i(ap),
    .addr_i(addr), .wdata_i(wdata), .be_i(be), .ready_o(ready), .rvalid_o(rvalid),
    .rdata_o(rdata), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n), .cas_n_o(cas_n),
    .we_n_o(we_n), .ba_o(ba), .a_o(a), .dqm_o(dqm), .dq_o(dq_o), .dq_oe_o(dq_oe),
    .dq_i(dq_i)
  );

  int errors = 0, checks = 0;
  logic [15:0] exp_q[$];
  logic [15:0] shadow[bit [23:0]];
  logic [15:0] mem[bit [23:0]];

  logic        exp_ap = 1'b0;
  logic [23:0] exp_addr = '0;
  logic [15:0] exp_wdata = '0;
  logic [1:0]  exp_be = '0;

  task automatic check(bit ok, string req_tag, string what, logic [31:0] act, logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] bmask(logic [1:0] b);
    return {{8{b[1]}}, {8{b[0]}}};
  endfunction

  // ---------------- memory model ----------------
  int cyc = 0, init_step = 0, nref = 0;
  int last_act = -1000, last_pre = -1000, last_ref = -1000, last_mrs = -1000, last_wr = -1000;
  bit mrs_done = 1'b0, pre_owed = 1'b0, early_ready = 1'b0;
  bit is_open[4];
  logic [12:0] open_row[4];
  bit pv[0:3];
  logic [15:0] pd[0:3];
  logic [1:0] dqm_prev = 2'b11;

  always @(posedge clk) begin
    if (rst_n) begin
      logic [2:0] c;
      logic [23:0] key;
      cyc++;
      if (pv[0]) dq_i <= pd[0] & ~bmask(dqm_prev);
      else       dq_i <= '0;
      for (int i = 0; i < 3; i++) begin pv[i] = pv[i+1]; pd[i] = pd[i+1]; end
      pv[3] = 1'b0;
      c = {ras_n, cas_n, we_n};
      if (!cs_n) begin
        if (!mrs_done) begin
          case (init_step)
            0: begin
              check(cyc >= TINIT, "R1", "first command edge", cyc, TINIT);
              check(c == 3'b010 && a[10], "R2", "init close-all", {c, a}, {3'b010, 13'h400});
            end
            1, 2: check(c == 3'b001, "R2", "init refresh", c, 3'b001);
            default: begin
              check(c == 3'b000 && a == 13'(CL << 4) && ba == 2'b00, "R2", "mode load",
                    {ba, c, a}, {2'b00, 3'b000, 13'(CL << 4)});
              mrs_done = 1'b1;
              last_mrs = cyc;
            end
          endcase
          if (c == 3'b001) last_ref = cyc;
          if (c == 3'b010) last_pre = cyc;
          init_step++;
        end else begin
          check(cyc - last_mrs >= TMRD, "R5", "mode load spacing", cyc - last_mrs, TMRD);
          case (c)
            3'b011: begin
              check(!pre_owed, "R6", "row open before owed close", pre_owed, 0);
              check(!is_open[ba], "R6", "row open on open bank", ba, 0);
              check({ba, a} == exp_addr[23:9], "R4", "row open address", {ba, a}, exp_addr[23:9]);
              check(cyc - last_pre >= TRP, "R5", "precharge spacing", cyc - last_pre, TRP);
              check(cyc - last_ref >= TRFC, "R5", "refresh spacing", cyc - last_ref, TRFC);
              is_open[ba] = 1'b1; open_row[ba] = a; last_act = cyc;
            end
            3'b100, 3'b101: begin
              check(is_open[ba], "R4", "column cmd to closed bank", ba, 1);
              check(ba == exp_addr[23:22] && a[8:0] == exp_addr[8:0] && a[9] == 1'b0 &&
                    a[12:11] == 2'b00, "R4", "column address", {ba, a}, {exp_addr[23:22], 13'(exp_addr[8:0])});
              check(a[10] == exp_ap, "R6", "auto close bit", a[10], exp_ap);
              check(cyc - last_act >= TRCD, "R5", "row to column spacing", cyc - last_act, TRCD);
              key = {ba, open_row[ba], a[8:0]};
              if (c == 3'b100) begin
                check(dq_oe && dq_o == exp_wdata && dqm == ~exp_be, "R7", "write pins",
                      {dq_oe, dqm, dq_o}, {1'b1, ~exp_be, exp_wdata});
                if (!mem.exists(key)) mem[key] = '0;
                mem[key] = (mem[key] & bmask(dqm)) | (dq_o & ~bmask(dqm));
                last_wr = cyc;
              end else begin
                pv[CL-2] = 1'b1;
                pd[CL-2] = mem.exists(key) ? mem[key] : 16'h0;
              end
              if (a[10]) is_open[ba] = 1'b0;
              else       pre_owed = 1'b1;
            end
            3'b010: begin
              check(cyc - last_wr >= TWR + 1, "R5", "write recovery", cyc - last_wr, TWR + 1);
              if (a[10]) begin
                for (int i = 0; i < 4; i++) is_open[i] = 1'b0;
              end else begin
                check(ba == exp_addr[23:22] && pre_owed, "R6", "single bank close", {pre_owed, ba}, {1'b1, exp_addr[23:22]});
                is_open[ba] = 1'b0;
              end
              pre_owed = 1'b0;
              last_pre = cyc;
            end
            3'b001: begin
              check(!is_open[0] && !is_open[1] && !is_open[2] && !is_open[3] && !pre_owed,
                    "R9", "refresh with open bank", {is_open[0], is_open[1], is_open[2], is_open[3]}, 0);
              check(cyc - last_ref <= REFI + SLACK, "R9", "refresh gap", cyc - last_ref, REFI);
              check(cyc - last_pre >= TRP, "R5", "precharge spacing", cyc - last_pre, TRP);
              check(cyc - last_ref >= TRFC, "R5", "refresh spacing", cyc - last_ref, TRFC);
              last_ref = cyc; nref++;
            end
            default: check(1'b0, "R3", "unexpected command code", c, 3'b111);
          endcase
        end
      end
      dqm_prev = dqm;
    end
  end

  // ---------------- monitor ----------------
  always @(negedge clk) begin
    if (rst_n) begin
      if (ready && !mrs_done) early_ready = 1'b1;
      if (rvalid) begin
        if (exp_q.size() == 0) check(1'b0, "R10", "unexpected read word", rdata, 0);
        else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          check(rdata == e, "R8", "read word", rdata, e);
        end
      end
    end
  end

  // ---------------- driver ----------------
  task automatic do_req(bit w, bit p, logic [23:0] ad, logic [15:0] d, logic [1:0] b);
    @(negedge clk);
    while (!ready) @(negedge clk);
    exp_ap = p; exp_addr = ad; exp_wdata = d; exp_be = b;
    req = 1'b1; we = w; ap = p; addr = ad; wdata = d; be = b;
    @(negedge clk);
    req = 1'b0;
    if (w) begin
      if (!shadow.exists(ad)) shadow[ad] = '0;
      shadow[ad] = (shadow[ad] & ~bmask(b)) | (d & bmask(b));
    end else begin
      exp_q.push_back((shadow.exists(ad) ? shadow[ad] : 16'h0) & bmask(b));
    end
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      check(1'b0, "R10", "watchdog expired", wd, 150000);
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1 && ready == 1'b0 && rvalid == 1'b0 && dq_oe == 1'b0, "R1", "reset pins",
          {cs_n, ready, rvalid, dq_oe}, 4'b1000);
    rst_n = 1'b1;
    // R1/R2: start-up then first accesses
    do_req(1, 1, {2'd0, 13'd5, 9'd7}, 16'hBEEF, 2'b11);
    do_req(0, 1, {2'd0, 13'd5, 9'd7}, 16'h0, 2'b11);
    // R6: explicit close path
    do_req(1, 0, {2'd1, 13'd100, 9'd3}, 16'h1234, 2'b11);
    do_req(0, 0, {2'd1, 13'd100, 9'd3}, 16'h0, 2'b11);
    do_req(0, 0, {2'd1, 13'd100, 9'd3}, 16'h0, 2'b11);
    // R7: partial writes
    do_req(1, 1, {2'd0, 13'd5, 9'd7}, 16'h55AA, 2'b01);
    do_req(0, 1, {2'd0, 13'd5, 9'd7}, 16'h0, 2'b11);
    do_req(1, 0, {2'd1, 13'd100, 9'd3}, 16'hC3C3, 2'b10);
    do_req(0, 1, {2'd1, 13'd100, 9'd3}, 16'h0, 2'b11);
    // R8: read masks on each byte
    do_req(0, 1, {2'd0, 13'd5, 9'd7}, 16'h0, 2'b10);
    do_req(0, 0, {2'd0, 13'd5, 9'd7}, 16'h0, 2'b01);
    do_req(0, 1, {2'd1, 13'd100, 9'd3}, 16'h0, 2'b00);
    // R4: address field extremes
    do_req(1, 1, {2'd3, 13'h1FFF, 9'h1FF}, 16'hA5C3, 2'b11);
    do_req(1, 0, {2'd2, 13'h0, 9'h0}, 16'h0F0F, 2'b11);
    do_req(0, 0, {2'd3, 13'h1FFF, 9'h1FF}, 16'h0, 2'b11);
    do_req(0, 1, {2'd2, 13'h0, 9'h0}, 16'h0, 2'b11);
    do_req(0, 1, {2'd3, 13'h1FFE, 9'h1FF}, 16'h0, 2'b11);
    // R9: idle long enough for several refreshes
    repeat (3 * REFI) @(negedge clk);
    for (int i = 0; i < 12; i++) begin
      do_req(1, i[0], {2'(i), 13'(i * 37), 9'(i * 11)}, 16'(i * 16'h1111 + 3), 2'b11);
      do_req(0, i[1], {2'(i), 13'(i * 37), 9'(i * 11)}, 16'h0, 2'b11);
    end
    repeat (20) @(negedge clk);
    check(!early_ready && mrs_done, "R1", "ready before start-up done", early_ready, 0);
    check(nref >= 3, "R9", "refresh count", nref, 3);
    check(exp_q.size() == 0, "R10", "reads left without data", exp_q.size(), 0);
    check(cke == 1'b1 && cs_n == 1'b1, "R3", "idle pins", {cke, cs_n}, 2'b11);
    finish_run();
  end
endmodule